// File: doc/BRIEF.md
# Filtered Input Capture Channel Bank

This block provides a small bank of input capture channels for a free-running timer whose count value is supplied from outside. Each channel watches one asynchronous pin. The pin is brought into the clock domain through a flop chain. A sample-agreement filter then turns it into a clean level. A level change of the polarity picked for that channel stores the present timer value in the channel's capture register and raises the channel's event flag.

Software reaches the block through a simple single-cycle register bus. Each channel has an interrupt mask bit, and one interrupt line is raised while any unmasked flag is set. A flag is cleared only by a two-step handshake: software reads the status word while the flag is up, then writes a zero to that bit. A capture that arrives after the read always survives the clearing write. The filtered pin levels can be read back at any time, so an unused channel serves as a general-purpose input.

Top module: `icap_bank`

## Requirements
- R1: After reset, all flags, capture registers, edge selections and interrupt masks read as zero, and `irq` is low.
- R2: The edge field of channel i sits at bits [2i+1:2i] of the edge register (address 1). The encodings are 00 none, 01 rising, 10 falling and 11 both. Only a filtered edge of a selected polarity sets flag i, which is bit i of the status register (address 0).
- R3: A pin level held across two or more consecutive rising clock edges is always accepted as a level change. A pulse wider than two clock periods therefore always counts.
- R4: A pin level present at only one rising clock edge is rejected. It causes no capture, no flag and no change in the filtered level.
- R5: On a capture, register i (address 4+i) takes the `timer_cnt` value present in the cycle the filtered level changes. That cycle is the third clock edge after the first edge that samples the new pin level.
- R6: `irq` is high exactly when some flag i is set and its mask bit i (address 2) is one.
- R7: A zero written to status bit i clears flag i only if the status register was read while flag i was set, and no write has consumed that read since. A zero written without such a read leaves the flag set.
- R8: Writing a one to a status bit changes neither the flag nor its pending read.
- R9: A capture on channel i after the status read, including one in the same cycle as the clearing write, leaves flag i set after that write.
- R10: Address 3 returns the filtered level of every pin at bit i, whatever the edge selection.
- R11: Each accepted selected edge overwrites capture register i, even while flag i is still set. With no accepted edge the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_cnt | input | CNT_W | Present value of the free-running timer |
| cap_pin | input | NUM_CH | Asynchronous capture pins, one per channel |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register |
| irq | output | 1 | Interrupt request |

## Verification
The capture path and the flag-clearing handshake can act on the same flag in the same clock cycle. The bench arms the handshake by reading the status register. It then raises a pin exactly three falling edges before a zero write, so the filtered edge and the clearing write land on the same clock edge. The result is correct only if the flag is still set afterwards and the capture register holds the new timer value. A second case puts the capture between the read and the write and expects the same outcome.

// File: rtl/icap_pkg.sv
package icap_pkg;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_ANY  = 2'b11
   } edge_sel_e;

   localparam int unsigned REG_STATUS   = 0;
   localparam int unsigned REG_EDGE     = 1;
   localparam int unsigned REG_IEN      = 2;
   localparam int unsigned REG_PIN      = 3;
   localparam int unsigned REG_CAP_BASE = 4;

endpackage

// File: rtl/icap_qualifier.sv
module icap_qualifier #(
   parameter int unsigned SYNC_DEPTH = 2,
   parameter bit          FILTER_EN  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);

   if (SYNC_DEPTH < 2) begin : g_bad_depth
      $error("icap_qualifier: SYNC_DEPTH must be at least 2");
   end

   logic [SYNC_DEPTH-1:0] sync_q;
   logic                  sync_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_DEPTH-2:0], pin_i};
   end

   assign sync_last = sync_q[SYNC_DEPTH-1];

   if (FILTER_EN) begin : g_filter
      logic prev_q;
      logic level_q;
      logic agree;

      assign agree = (sync_last == prev_q);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q  <= 1'b0;
            level_q <= 1'b0;
         end else begin
            prev_q <= sync_last;
            if (agree && (sync_last != level_q)) level_q <= sync_last;
         end
      end

      assign rise_o  = agree &  sync_last & ~level_q;
      assign fall_o  = agree & ~sync_last &  level_q;
      assign level_o = level_q;

      // R4: a new level is taken only after two consecutive equal samples
      p_accept_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(level_q) |-> ($past(sync_last) && $past(sync_last, 2)));
      p_release_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(level_q) |-> (!$past(sync_last) && !$past(sync_last, 2)));
   end else begin : g_nofilter
      logic level_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) level_q <= 1'b0;
         else        level_q <= sync_last;
      end

      assign rise_o  =  sync_last & ~level_q;
      assign fall_o  = ~sync_last &  level_q;
      assign level_o = level_q;
   end

endmodule

// File: rtl/icap_channel.sv
module icap_channel
   import icap_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  edge_sel_e        sel_i,
   input  logic             rise_i,
   input  logic             fall_i,
   input  logic [CNT_W-1:0] timer_i,
   output logic             capture_o,
   output logic [CNT_W-1:0] value_o
);

   logic             want_rise;
   logic             want_fall;
   logic [CNT_W-1:0] cap_q;

   always_comb begin
      want_rise = 1'b0;
      want_fall = 1'b0;
      case (sel_i)
         EDGE_RISE: want_rise = 1'b1;
         EDGE_FALL: want_fall = 1'b1;
         EDGE_ANY: begin
            want_rise = 1'b1;
            want_fall = 1'b1;
         end
         default: ;
      endcase
   end

   assign capture_o = (rise_i & want_rise) | (fall_i & want_fall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cap_q <= '0;
      else if (capture_o) cap_q <= timer_i;
   end

   assign value_o = cap_q;

   // R5: stored value is the timer value of the capture cycle
   p_cap_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      capture_o |=> (cap_q == $past(timer_i)));
   // R11: no accepted edge, no change
   p_cap_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !capture_o |=> $stable(cap_q));

endmodule

// File: rtl/icap_flags.sv
module icap_flags #(
   parameter int unsigned NUM_CH = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] set_i,
   input  logic              rd_stat_i,
   input  logic              wr_stat_i,
   input  logic [NUM_CH-1:0] wdata_i,
   input  logic [NUM_CH-1:0] ien_i,
   output logic [NUM_CH-1:0] flags_o,
   output logic              irq_o
);

   logic [NUM_CH-1:0] flags_q;
   logic [NUM_CH-1:0] armed_q;
   logic [NUM_CH-1:0] zero_wr;

   assign zero_wr = {NUM_CH{wr_stat_i}} & ~wdata_i;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flags_q[i] <= 1'b0;
            armed_q[i] <= 1'b0;
         end else begin
            // a capture always wins and withdraws any pending read
            if (set_i[i])                       flags_q[i] <= 1'b1;
            else if (zero_wr[i] && armed_q[i])  flags_q[i] <= 1'b0;

            if (set_i[i])                       armed_q[i] <= 1'b0;
            else if (zero_wr[i])                armed_q[i] <= 1'b0;
            else if (rd_stat_i && flags_q[i])   armed_q[i] <= 1'b1;
         end
      end

      // R7: a pending read exists only for a set flag
      p_arm_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
         armed_q[i] |-> flags_q[i]);
      // R7: a flag drops only through an armed zero write
      p_clear_by_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(flags_q[i]) |->
            ($past(wr_stat_i) && !$past(wdata_i[i]) && $past(armed_q[i])));
      // R8: writes never raise a flag
      p_no_set_by_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flags_q[i]) |-> $past(set_i[i]));
      // R9: a capture event always leaves the flag set
      p_capture_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> flags_q[i]);
   end

   assign flags_o = flags_q;
   assign irq_o   = |(flags_q & ien_i);

endmodule

// File: rtl/icap_bank.sv
module icap_bank
   import icap_pkg::*;
#(
   parameter int unsigned NUM_CH     = 3,
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned SYNC_DEPTH = 2,
   parameter bit          FILTER_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  timer_cnt,
   input  logic [NUM_CH-1:0] cap_pin,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);

   localparam int unsigned EDGE_W = 2 * NUM_CH;
   localparam int unsigned REG_CNT = REG_CAP_BASE + NUM_CH;

   if (NUM_CH < 1)              begin : g_bad_ch   $error("icap_bank: NUM_CH must be at least 1"); end
   if (EDGE_W > DATA_W)         begin : g_bad_edge $error("icap_bank: edge fields exceed DATA_W"); end
   if (CNT_W > DATA_W)          begin : g_bad_cnt  $error("icap_bank: CNT_W exceeds DATA_W"); end
   if (REG_CNT > (1 << ADDR_W)) begin : g_bad_addr $error("icap_bank: ADDR_W too small"); end

   logic [EDGE_W-1:0] edge_cfg_q;
   logic [NUM_CH-1:0] ien_q;
   logic [NUM_CH-1:0] level;
   logic [NUM_CH-1:0] rise;
   logic [NUM_CH-1:0] fall;
   logic [NUM_CH-1:0] capture;
   logic [NUM_CH-1:0] flags;
   logic [CNT_W-1:0]  cap_val [NUM_CH];
   logic              rd_stat;
   logic              wr_stat;
   logic              wr_edge;
   logic              wr_ien;
   logic              unused_wdata;

   assign unused_wdata = ^bus_wdata;

   assign rd_stat = bus_sel & ~bus_wr & (bus_addr == ADDR_W'(REG_STATUS));
   assign wr_stat = bus_sel &  bus_wr & (bus_addr == ADDR_W'(REG_STATUS));
   assign wr_edge = bus_sel &  bus_wr & (bus_addr == ADDR_W'(REG_EDGE));
   assign wr_ien  = bus_sel &  bus_wr & (bus_addr == ADDR_W'(REG_IEN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_cfg_q <= '0;
         ien_q      <= '0;
      end else begin
         if (wr_edge) edge_cfg_q <= bus_wdata[EDGE_W-1:0];
         if (wr_ien)  ien_q      <= bus_wdata[NUM_CH-1:0];
      end
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      icap_qualifier #(
         .SYNC_DEPTH (SYNC_DEPTH),
         .FILTER_EN  (FILTER_EN)
      ) u_qual (
         .clk     (clk),
         .rst_n   (rst_n),
         .pin_i   (cap_pin[i]),
         .level_o (level[i]),
         .rise_o  (rise[i]),
         .fall_o  (fall[i])
      );

      icap_channel #(
         .CNT_W (CNT_W)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .sel_i     (edge_sel_e'(edge_cfg_q[2*i +: 2])),
         .rise_i    (rise[i]),
         .fall_i    (fall[i]),
         .timer_i   (timer_cnt),
         .capture_o (capture[i]),
         .value_o   (cap_val[i])
      );
   end

   icap_flags #(
      .NUM_CH (NUM_CH)
   ) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (capture),
      .rd_stat_i (rd_stat),
      .wr_stat_i (wr_stat),
      .wdata_i   (bus_wdata[NUM_CH-1:0]),
      .ien_i     (ien_q),
      .flags_o   (flags),
      .irq_o     (irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(REG_STATUS)) bus_rdata[NUM_CH-1:0] = flags;
      if (bus_addr == ADDR_W'(REG_EDGE))   bus_rdata[EDGE_W-1:0] = edge_cfg_q;
      if (bus_addr == ADDR_W'(REG_IEN))    bus_rdata[NUM_CH-1:0] = ien_q;
      if (bus_addr == ADDR_W'(REG_PIN))    bus_rdata[NUM_CH-1:0] = level;
      for (int i = 0; i < NUM_CH; i++) begin
         if (bus_addr == ADDR_W'(REG_CAP_BASE + i)) bus_rdata[CNT_W-1:0] = cap_val[i];
      end
   end

   // R6: no request without an unmasked flag present on the previous edge's state
   p_irq_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (|flags));
   // R2: a disabled channel never captures
   p_off_no_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_cfg_q[1:0] == 2'b00) |-> !capture[0]);

endmodule

// File: tb/tb_icap_bank.sv
module tb_icap_bank;

   localparam int NCH = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] timer_cnt = '0;
   logic [2:0]  cap_pin = '0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   icap_bank dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .timer_cnt (timer_cnt),
      .cap_pin   (cap_pin),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   typedef struct packed {
      logic [1:0]  ch;
      logic [1:0]  cfg;
      logic [3:0]  width;
      logic        low;
      logic [15:0] tval;
      logic        hit;
   } vec_t;

   localparam int NVEC = 10;
   localparam vec_t VEC [NVEC] = '{
      '{2'd0, 2'b01, 4'd3, 1'b0, 16'h1A01, 1'b1},
      '{2'd0, 2'b10, 4'd3, 1'b0, 16'h1A02, 1'b1},
      '{2'd1, 2'b11, 4'd2, 1'b0, 16'h1A03, 1'b1},
      '{2'd1, 2'b01, 4'd1, 1'b0, 16'h1A04, 1'b0},
      '{2'd2, 2'b00, 4'd4, 1'b0, 16'h1A05, 1'b0},
      '{2'd2, 2'b10, 4'd3, 1'b1, 16'h1A06, 1'b1},
      '{2'd0, 2'b01, 4'd3, 1'b1, 16'h1A07, 1'b1},
      '{2'd1, 2'b10, 4'd1, 1'b1, 16'h1A08, 1'b0},
      '{2'd2, 2'b11, 4'd5, 1'b1, 16'h1A09, 1'b1},
      '{2'd0, 2'b10, 4'd2, 1'b1, 16'h1A0A, 1'b1}
   };

   logic [15:0] exp_cap [NCH];
   logic [5:0]  cfg_shadow = '0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input int a, input logic [15:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read(input int a, output logic [15:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'(a);
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic clear_all();
      logic [15:0] d;
      bus_read(0, d);
      bus_write(0, 16'h0000);
   endtask

   task automatic set_cfg(input int ch, input logic [1:0] c);
      cfg_shadow[2*ch +: 2] = c;
      bus_write(1, {10'd0, cfg_shadow});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] d;
      for (int i = 0; i < NCH; i++) exp_cap[i] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      bus_read(0, d); check("R1 status", d, 0);
      bus_read(1, d); check("R1 edge cfg", d, 0);
      bus_read(2, d); check("R1 ien", d, 0);
      for (int i = 0; i < NCH; i++) begin
         bus_read(4 + i, d); check("R1 capture reg", d, 0);
      end
      check("R1 irq", irq, 0);

      bus_write(2, 16'h0007);

      // vector table: R2 R3 R4 R5 R6 R10
      for (int v = 0; v < NVEC; v++) begin
         int ch;
         ch = int'(VEC[v].ch);
         set_cfg(ch, 2'b00);
         cap_pin[ch] = VEC[v].low;
         repeat (6) @(negedge clk);
         bus_read(3, d); check("R10 pin level", d[ch], VEC[v].low);
         clear_all();
         set_cfg(ch, VEC[v].cfg);
         timer_cnt = VEC[v].tval;
         cap_pin[ch] = ~VEC[v].low;
         repeat (int'(VEC[v].width)) @(negedge clk);
         cap_pin[ch] = VEC[v].low;
         repeat (8) @(negedge clk);
         if (VEC[v].hit) exp_cap[ch] = VEC[v].tval;
         bus_read(0, d); check("R2/R3/R4 flag", d, {13'd0, 3'(VEC[v].hit) << ch});
         bus_read(4 + ch, d); check("R5 capture value", d, exp_cap[ch]);
         check("R6 irq", irq, VEC[v].hit);
      end

      // directed setup on channel 0
      set_cfg(0, 2'b00); set_cfg(1, 2'b00); set_cfg(2, 2'b00);
      cap_pin = '0;
      repeat (6) @(negedge clk);
      clear_all();
      set_cfg(0, 2'b01);

      // R7: zero write without a read does not clear
      timer_cnt = 16'h1111;
      cap_pin[0] = 1'b1;
      repeat (8) @(negedge clk);
      bus_write(0, 16'h0000);
      bus_read(0, d); check("R7 unread zero write", d, 16'h0001);
      bus_write(0, 16'h0000);
      bus_read(0, d); check("R7 read then zero write", d, 16'h0000);

      // R8: writing ones has no effect, the pending read survives
      cap_pin[0] = 1'b0; repeat (6) @(negedge clk);
      timer_cnt = 16'h2222;
      cap_pin[0] = 1'b1; repeat (8) @(negedge clk);
      bus_read(0, d);
      bus_write(0, 16'h0007);
      bus_read(4, d); check("R8 capture after ones write", d, 16'h2222);
      bus_read(0, d); check("R8 ones write keeps flag", d, 16'h0001);
      bus_write(0, 16'h0000);
      bus_read(0, d); check("R8 later zero write clears", d, 16'h0000);

      // R9 / R11: capture between read and write
      cap_pin[0] = 1'b0; repeat (6) @(negedge clk);
      timer_cnt = 16'h3333;
      cap_pin[0] = 1'b1; repeat (8) @(negedge clk);
      bus_read(0, d);
      cap_pin[0] = 1'b0; repeat (6) @(negedge clk);
      timer_cnt = 16'h4444;
      cap_pin[0] = 1'b1; repeat (8) @(negedge clk);
      bus_write(0, 16'h0000);
      bus_read(0, d); check("R9 capture after read keeps flag", d, 16'h0001);
      bus_read(4, d); check("R11 overwrite while flag set", d, 16'h4444);
      clear_all();
      bus_read(0, d); check("R7 clear after race", d, 16'h0000);

      // R9: capture in the same cycle as the clearing write
      cap_pin[0] = 1'b0; repeat (6) @(negedge clk);
      timer_cnt = 16'h5555;
      cap_pin[0] = 1'b1; repeat (8) @(negedge clk);
      bus_read(0, d);
      cap_pin[0] = 1'b0; repeat (6) @(negedge clk);
      timer_cnt = 16'h6666;
      cap_pin[0] = 1'b1;
      @(negedge clk); @(negedge clk); @(negedge clk);
      bus_write(0, 16'h0000);
      repeat (2) @(negedge clk);
      bus_read(0, d); check("R9 same-cycle capture keeps flag", d, 16'h0001);
      bus_read(4, d); check("R5 same-cycle capture value", d, 16'h6666);

      // R6: masking
      bus_write(2, 16'h0006);
      @(negedge clk);
      check("R6 masked irq", irq, 0);
      bus_write(2, 16'h0001);
      @(negedge clk);
      check("R6 unmasked irq", irq, 1);
      clear_all();
      check("R6 irq after clear", irq, 0);

      // R10 / R11: general-purpose readback with capture disabled
      set_cfg(0, 2'b00);
      timer_cnt = 16'h7777;
      cap_pin = 3'b101;
      repeat (8) @(negedge clk);
      bus_read(3, d); check("R10 pin readback", d, 16'h0005);
      bus_read(0, d); check("R2 disabled no flag", d, 16'h0000);
      bus_read(4, d); check("R11 disabled holds capture", d, 16'h6666);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule